// File: doc/BRIEF.md
# Conditional Branch and Set Unit

This unit executes the conditional control-flow group of a 32-bit processor. Every instruction in the group carries a 4-bit condition code. The unit evaluates that code against the zero (Z), negative (N), overflow (V) and carry (C) flags and then acts on the result in one of three ways:

- it redirects the program counter to an absolute, word-aligned target;
- it redirects to a target formed from a register value plus a scaled signed offset;
- it writes a boolean 0 or 1 into a register.

The unit has one architectural delay slot. A taken branch does not change the flow at once. The instruction after it still runs, and only then does execution continue at the target.

Each cycle in which `instr_valid` is high, the unit receives one executed instruction together with its own PC, the flags and the value read for the register in bits 22:18. In the same cycle it returns the address of the next instruction to execute and, for the set-on-condition form, a register write.

A one-entry pending-redirect register carries a taken target across exactly one following valid instruction, whatever kind that instruction is. Cycles with `instr_valid` low leave that register alone. Fetch and the register file sit outside the unit.

Top module: `cond_branch_unit`

## Requirements
- R1: After reset no redirect is pending, so the first valid instruction yields `next_pc` = `pc`+4, and `wr_en` is 0.
- R2: The condition code is `{instr[27:25], instr[0]}` and holds as follows. 0000 always; 0001 never; 0010 C&~Z; 0011 ~C|Z; 0100 ~C; 0101 C; 0110 ~Z; 0111 Z; 1000 ~V; 1001 V; 1010 ~N; 1011 N; 1100 N==V; 1101 N!=V; 1110 ~Z&(N==V); 1111 Z|(N!=V).
- R3: An instruction with `instr[31:28]`=1110 and `instr[1]`=0 is an absolute branch. Its target is `{7'b0, instr[24:2], 2'b00}`.
- R4: An instruction with `instr[31:28]`=1110, `instr[1]`=1 and `instr[24]`=1 is a relative branch. Its target is `rs1_val` + 4*sign-extend(`instr[15:2]`), wrapping modulo 2^32.
- R5: An instruction with `instr[31:28]`=1110, `instr[1]`=1 and `instr[24]`=0 is set-on-condition. It drives `wr_en`=1, `wr_addr`=`instr[22:18]` and `wr_data` = 32'h1 if the condition holds and 32'h0 otherwise. It never redirects.
- R6: For a taken branch, its own `next_pc` is `pc`+4. The next valid instruction (the delay slot) reports the branch target as its `next_pc`.
- R7: A branch whose condition is false acts as a no-op. The next valid instruction reports its own `pc`+4.
- R8: If the delay-slot instruction is itself a taken branch, it reports the first target as its `next_pc`, and the instruction after it reports the second target.
- R9: A valid instruction whose `instr[31:28]` is not 1110 writes nothing (`wr_en`=0) and starts no redirect. It still consumes a pending redirect as the delay slot.
- R10: Cycles with `instr_valid` low keep a pending redirect unchanged and hold `wr_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction executes this cycle |
| instr | input | 32 | Instruction word |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| rs1_val | input | 32 | Value of the register named in bits 22:18 |
| pc | input | 32 | Address of the executing instruction |
| next_pc | output | 32 | Address of the next instruction to execute |
| wr_en | output | 1 | Register write strobe (set-on-condition) |
| wr_addr | output | 5 | Register written |
| wr_data | output | 32 | Boolean value written |

## Verification
The register write and `next_pc` are combinational, so both are due in the same cycle as the instruction that causes them. A redirect is due only on the next valid instruction, however many idle cycles come between.

The driver applies each instruction just after a falling edge and queues the values the requirements predict for that instruction. Its model of the pending redirect advances only on valid instructions. The monitor pops and compares those values four nanoseconds later, before the next rising edge commits the pending state.

// File: rtl/cond_branch_unit.sv
module cond_branch_unit #(
  parameter logic [3:0] GROUP_OPC = 4'b1110
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [31:0] instr,
  input  logic        flag_z,
  input  logic        flag_n,
  input  logic        flag_v,
  input  logic        flag_c,
  input  logic [31:0] rs1_val,
  input  logic [31:0] pc,
  output logic [31:0] next_pc,
  output logic        wr_en,
  output logic [4:0]  wr_addr,
  output logic [31:0] wr_data
);
  localparam int W = 32;

  logic        in_group, is_abs, is_rel, is_set;
  logic        base, cond, br_take;
  logic [W-1:0] abs_tgt, rel_tgt, br_tgt;
  logic        pend_v;
  logic [W-1:0] pend_tgt;

  assign in_group = instr_valid && (instr[31:28] == GROUP_OPC);
  assign is_abs   = in_group && !instr[1];
  assign is_rel   = in_group && instr[1] && instr[24];
  assign is_set   = in_group && instr[1] && !instr[24];

  always_comb begin
    case (instr[27:25])
      3'd0: base = 1'b1;
      3'd1: base = flag_c & ~flag_z;
      3'd2: base = ~flag_c;
      3'd3: base = ~flag_z;
      3'd4: base = ~flag_v;
      3'd5: base = ~flag_n;
      3'd6: base = ~(flag_n ^ flag_v);
      default: base = ~flag_z & ~(flag_n ^ flag_v);
    endcase
  end
  assign cond = base ^ instr[0];

  assign abs_tgt = {7'b0, instr[24:2], 2'b00};
  assign rel_tgt = rs1_val + {{16{instr[15]}}, instr[15:2], 2'b00};
  assign br_tgt  = is_abs ? abs_tgt : rel_tgt;
  assign br_take = (is_abs || is_rel) && cond;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_tgt <= '0;
    end else if (instr_valid) begin
      pend_v   <= br_take;
      pend_tgt <= br_tgt;
    end
  end

  assign next_pc = pend_v ? pend_tgt : pc + 32'd4;
  assign wr_en   = is_set;
  assign wr_addr = instr[22:18];
  assign wr_data = {31'b0, is_set && cond};

  AST_RESET_CLEAN: assert property (@(posedge clk) !rst_n |=> !pend_v); // R1
  AST_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (is_abs && instr[27:25] == 3'd0 && !instr[0]) |=> pend_v); // R2
  AST_NEVER_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_group && instr[27:25] == 3'd0 && instr[0]) |=> !pend_v); // R7
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !pend_v) |-> next_pc == pc + 32'd4); // R6
  AST_WRITE_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (instr_valid && instr[31:28] == GROUP_OPC && instr[1] && !instr[24])); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> ($stable(pend_v) && $stable(pend_tgt))); // R10
  AST_OTHER_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[31:28] != GROUP_OPC) |=> !pend_v); // R9
endmodule

// File: tb/sim_cond_branch_unit.sv
module sim_cond_branch_unit;
  logic clk = 0, rst_n = 0, instr_valid = 0;
  logic [31:0] instr = 0, rs1_val = 0, pc = 0;
  logic fz = 0, fn = 0, fv = 0, fc = 0;
  logic [31:0] next_pc, wr_data;
  logic wr_en;
  logic [4:0] wr_addr;

  always #5 clk = ~clk;

  cond_branch_unit u0 (.clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .flag_z(fz), .flag_n(fn), .flag_v(fv), .flag_c(fc), .rs1_val(rs1_val), .pc(pc),
    .next_pc(next_pc), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  typedef struct {
    logic [31:0] npc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit exp_pend = 0;
  logic [31:0] exp_tgt = 0;
  bit done = 0;

  function automatic bit cond_of(input logic [3:0] k, input logic z, n, v, c);
    case (k)
      4'h0: return 1; 4'h1: return 0;
      4'h2: return c & !z; 4'h3: return !c | z;
      4'h4: return !c; 4'h5: return c;
      4'h6: return !z; 4'h7: return z;
      4'h8: return !v; 4'h9: return v;
      4'hA: return !n; 4'hB: return n;
      4'hC: return n == v; 4'hD: return n != v;
      4'hE: return !z & (n == v); default: return z | (n != v);
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] iw, input logic [31:0] p, input logic [31:0] r1,
                       input logic [3:0] fl, input string tag);
    exp_t e;
    bit grp, taken;
    logic [31:0] tgt;
    @(negedge clk);
    instr_valid = 1; instr = iw; pc = p; rs1_val = r1;
    {fz, fn, fv, fc} = fl;
    grp = (iw[31:28] == 4'b1110);
    e.npc = exp_pend ? exp_tgt : p + 4;
    e.we = grp && iw[1] && !iw[24];
    e.wa = e.we ? iw[22:18] : 5'd0;
    e.wd = (e.we && cond_of({iw[27:25], iw[0]}, fl[3], fl[2], fl[1], fl[0])) ? 32'd1 : 32'd0;
    e.tag = tag;
    taken = grp && !e.we && cond_of({iw[27:25], iw[0]}, fl[3], fl[2], fl[1], fl[0]);
    tgt = !iw[1] ? {7'b0, iw[24:2], 2'b00} : r1 + {{16{iw[15]}}, iw[15:2], 2'b00};
    exp_pend = taken;
    exp_tgt = tgt;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      instr_valid = 0;
      instr = 32'hE000_0002;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (instr_valid && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "next_pc", next_pc, e.npc);
        chk(e.tag, "wr_en", {31'b0, wr_en}, {31'b0, e.we});
        if (e.we) begin
          chk(e.tag, "wr_addr", {27'b0, wr_addr}, {27'b0, e.wa});
          chk(e.tag, "wr_data", wr_data, e.wd);
        end
      end else if (!instr_valid && rst_n) begin
        chk("R10", "idle wr_en", {31'b0, wr_en}, 32'd0);
      end
    end
  end

  function automatic logic [31:0] scc(input logic [3:0] k, input logic [4:0] rd);
    return {4'b1110, k[3:1], 1'b0, 1'b0, rd, 16'h0, 1'b1, k[0]};
  endfunction
  function automatic logic [31:0] babs(input logic [3:0] k, input logic [24:0] a);
    return {4'b1110, k[3:1], a[24:2], 1'b0, k[0]};
  endfunction
  function automatic logic [31:0] brel(input logic [3:0] k, input logic [13:0] off);
    return {4'b1110, k[3:1], 1'b1, 1'b0, 5'd3, 2'b00, off, 1'b1, k[0]};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    drive(32'h0000_0000, 32'h100, 0, 4'h0, "R1");
    for (int f = 0; f < 16; f++)
      for (int k = 0; k < 16; k++)
        drive(scc(k[3:0], 5'(k + f)), 32'h200 + 32'(k * 4), 0, f[3:0], "R2");
    drive(scc(4'h7, 5'd31), 32'h300, 0, 4'b1000, "R5");
    drive(babs(4'h0, 25'h1AB_CDE4), 32'h400, 0, 4'h0, "R3");
    drive(32'h1234_5678, 32'h404, 0, 4'h0, "R6");
    drive(babs(4'h7, 25'h0000_800), 32'h1AB_CDE4, 0, 4'b0000, "R7");
    drive(32'h0, 32'h1AB_CDE8, 0, 4'h0, "R7");
    drive(brel(4'hD, 14'h3FFC), 32'h500, 32'h0000_1000, 4'b0100, "R4");
    drive(32'h0, 32'h504, 0, 4'h0, "R6");
    drive(brel(4'h0, 14'h0010), 32'h0FF0, 32'hFFFF_FFF0, 4'h0, "R4");
    drive(babs(4'h0, 25'h000_0400), 32'h0FF4, 0, 4'h0, "R8");
    drive(32'h0, 32'h0000_0030, 0, 4'h0, "R8");
    drive(32'h0, 32'h0000_0400, 0, 4'h0, "R8");
    drive(babs(4'h1, 25'h000_0040), 32'h600, 0, 4'hF, "R7");
    drive(32'h0, 32'h604, 0, 4'h0, "R7");
    drive(babs(4'hE, 25'h000_0080), 32'h700, 0, 4'b0000, "R2");
    idle(3);
    drive(32'h8000_0000, 32'h704, 0, 4'h0, "R10");
    drive(32'hF000_0006, 32'h080, 0, 4'h0, "R9");
    drive(32'h0, 32'h084, 0, 4'h0, "R9");
    @(negedge clk);
    instr_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule